// File: doc/BRIEF.md
# Single-Cycle Accumulator ALU

This block is the arithmetic and logic unit of an 8-bit accumulator-based microcontroller core that runs every instruction in one clock. Each time the core issues an instruction it presents the accumulator, a second operand and a 4-bit operation code. The second operand is taken either from an immediate byte out of program memory or from a byte out of the register file. The core also presents the current carry, auxiliary-carry and overflow flags. One clock edge later the block shows a registered high result byte, a registered low result byte and the three updated flags.

Every operation finishes within that single cycle, including multiply and divide. Divide uses an unrolled array of compare-and-subtract stages, not an iterative divider. While no instruction is issued the result and the flags stay frozen. A consumer can therefore read them at any later cycle. The flag inputs feed directly into the computation, so reissuing the same operation with different flags gives a new, correct result.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `res_hi`, `res_lo`, `cy_out`, `ac_out` and `ov_out` are all 0, and an `issue` pulse has no effect.
- R2: Outputs change only on a clock edge where `issue` is 1, and they show that instruction's result from the following cycle on. With `issue` at 0 every output holds its value.
- R3: The second operand B is `code_byte` when `use_imm` is 1 and `reg_byte` when `use_imm` is 0. The first operand is always `acc`.
- R4: Op 0 (add) and op 1 (add with carry): `res_lo` = (acc + B + cin) mod 256, where cin is 0 for op 0 and `cy_in` for op 1. `cy_out` is the carry out of bit 7, `ac_out` is the carry out of bit 3, and `ov_out` flags a two's-complement overflow. `res_hi` = 0.
- R5: Op 2 (subtract with borrow): `res_lo` = (acc − B − `cy_in`) mod 256. `cy_out` is the borrow out of bit 7, `ac_out` is the borrow out of bit 3, and `ov_out` flags a two's-complement overflow. `res_hi` = 0.
- R6: Op 3 (increment) and op 4 (decrement): `res_lo` = acc ± 1 mod 256. `res_hi` = 0, and the three flags equal their inputs.
- R7: Op 5 AND, op 6 OR and op 7 XOR put acc op B in `res_lo`. Op 8 puts the complement of acc in `res_lo`. For all four, `res_hi` = 0 and the flags equal their inputs.
- R8: Op 9 (multiply): {`res_hi`,`res_lo`} = acc × B. `cy_out` = 0, `ov_out` = 1 exactly when `res_hi` is non-zero, and `ac_out` = `ac_in`.
- R9: Op 10 (divide) with B ≠ 0: `res_lo` = acc / B and `res_hi` = acc mod B. `cy_out` = 0, `ov_out` = 0 and `ac_out` = `ac_in`.
- R10: Op 10 with B = 0: `ov_out` = 1, `cy_out` = 0, `res_lo` = FFh and `res_hi` = acc.
- R11: Op 11 (decimal adjust of acc): add 06h if the low nibble is above 9 or `ac_in` is 1. Then add 60h if the high nibble of that sum is above 9 or the carry is already set. `cy_out` is `cy_in` ORed with any carry out of bit 7 from either step. `res_hi` = 0, and `ac_out` and `ov_out` equal their inputs.
- R12: Ops 12 to 15: `res_lo` = acc, `res_hi` = 0, and the flags equal their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| op | input | 4 | Operation code |
| use_imm | input | 1 | Selects the program-memory byte as operand B |
| acc | input | 8 | Accumulator operand |
| code_byte | input | 8 | Immediate byte from program memory |
| reg_byte | input | 8 | Byte from the register file |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| res_hi | output | 8 | Registered high result byte |
| res_lo | output | 8 | Registered low result byte |
| cy_out | output | 1 | Registered carry flag |
| ac_out | output | 1 | Registered auxiliary-carry flag |
| ov_out | output | 1 | Registered overflow flag |

## Verification
Some properties the assertions watch on every cycle:
- outputs hold while nothing is issued;
- multiply clears carry and ties overflow to a non-zero high byte;
- a non-zero divisor always leaves a remainder smaller than the divisor, with overflow clear;
- a zero divisor yields the fixed FFh / acc pattern;
- logic ops pass the flags through;
- decimal adjust never clears a set carry.

Only the bench's reference model can show that the exact sums, differences, products and quotients are right, including the nibble carries and signed overflow. The same holds for the decimal-adjust corrections and for the operand-select path. The bench compares its model against the outputs after every clock, across directed corner cases and a long pseudo-random sweep with idle cycles mixed in.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;

    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_ADDC = 4'd1;
    localparam logic [3:0] OP_SUBB = 4'd2;
    localparam logic [3:0] OP_INC  = 4'd3;
    localparam logic [3:0] OP_DEC  = 4'd4;
    localparam logic [3:0] OP_AND  = 4'd5;
    localparam logic [3:0] OP_OR   = 4'd6;
    localparam logic [3:0] OP_XOR  = 4'd7;
    localparam logic [3:0] OP_CPL  = 4'd8;
    localparam logic [3:0] OP_MUL  = 4'd9;
    localparam logic [3:0] OP_DIV  = 4'd10;
    localparam logic [3:0] OP_DA   = 4'd11;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic              cy;
        logic              ac;
        logic              ov;
    } alu_res_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hc,
    output logic         ovf
);
    localparam int H = W / 2;

    logic [W:0] full;
    logic [H:0] half;

    always_comb begin
        if (!sub) begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            half = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
            ovf  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
        end else begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            half = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, cin};
            ovf  = (a[W-1] != b[W-1]) && (full[W-1] != a[W-1]);
        end
        sum  = full[W-1:0];
        cout = full[W];
        hc   = half[H];
    end
endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
    parameter int W = 8
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] part [0:W];

    assign part[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic [W:0] trial;
        logic [W:0] diff;
        assign trial = {part[i], num[W-1-i]};
        assign diff  = trial - {1'b0, den};
        assign quo[W-1-i] = ~diff[W];
        assign part[i+1]  = diff[W] ? trial[W-1:0] : diff[W-1:0];
    end

    assign rem = part[W];
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj (
    input  logic [7:0] a,
    input  logic       cy_in,
    input  logic       ac_in,
    output logic [7:0] res,
    output logic       cy_out
);
    logic [8:0] step1;
    logic [8:0] step2;
    logic       cy_mid;

    always_comb begin
        if ((a[3:0] > 4'd9) || ac_in) begin
            step1 = {1'b0, a} + 9'h006;
        end else begin
            step1 = {1'b0, a};
        end
        cy_mid = cy_in | step1[8];
        if ((step1[7:4] > 4'd9) || cy_mid) begin
            step2 = {1'b0, step1[7:0]} + 9'h060;
        end else begin
            step2 = {1'b0, step1[7:0]};
        end
        res    = step2[7:0];
        cy_out = cy_mid | step2[8];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        op,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] code_byte,
    input  logic [DATA_W-1:0] reg_byte,
    input  logic              cy_in,
    input  logic              ac_in,
    input  logic              ov_in,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo,
    output logic              cy_out,
    output logic              ac_out,
    output logic              ov_out
);
    localparam int PROD_W = 2 * DATA_W;

    alu_res_t res_d, res_q;

    logic [DATA_W-1:0] opnd_b;
    logic              as_cin, as_sub;
    logic [DATA_W-1:0] as_sum;
    logic              as_cout, as_hc, as_ovf;
    logic [DATA_W-1:0] dv_quo, dv_rem;
    logic [DATA_W-1:0] da_res;
    logic              da_cy;
    logic [PROD_W-1:0] product;

    assign opnd_b  = use_imm ? code_byte : reg_byte;
    assign as_sub  = (op == OP_SUBB);
    assign as_cin  = (op == OP_ADD) ? 1'b0 : cy_in;
    assign product = PROD_W'(acc) * PROD_W'(opnd_b);

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a(acc), .b(opnd_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .hc(as_hc), .ovf(as_ovf)
    );

    alu8_div #(.W(DATA_W)) u_div (
        .num(acc), .den(opnd_b), .quo(dv_quo), .rem(dv_rem)
    );

    alu8_decadj u_decadj (
        .a(acc), .cy_in(cy_in), .ac_in(ac_in),
        .res(da_res), .cy_out(da_cy)
    );

    always_comb begin
        res_d.hi = '0;
        res_d.lo = acc;
        res_d.cy = cy_in;
        res_d.ac = ac_in;
        res_d.ov = ov_in;
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                res_d.lo = as_sum;
                res_d.cy = as_cout;
                res_d.ac = as_hc;
                res_d.ov = as_ovf;
            end
            OP_INC: res_d.lo = acc + 1'b1;
            OP_DEC: res_d.lo = acc - 1'b1;
            OP_AND: res_d.lo = acc & opnd_b;
            OP_OR:  res_d.lo = acc | opnd_b;
            OP_XOR: res_d.lo = acc ^ opnd_b;
            OP_CPL: res_d.lo = ~acc;
            OP_MUL: begin
                res_d.hi = product[PROD_W-1:DATA_W];
                res_d.lo = product[DATA_W-1:0];
                res_d.cy = 1'b0;
                res_d.ov = |product[PROD_W-1:DATA_W];
            end
            OP_DIV: begin
                res_d.hi = dv_rem;
                res_d.lo = dv_quo;
                res_d.cy = 1'b0;
                res_d.ov = (opnd_b == '0);
            end
            OP_DA: begin
                res_d.lo = da_res;
                res_d.cy = da_cy;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (issue) begin
            res_q <= res_d;
        end
    end

    assign res_hi = res_q.hi;
    assign res_lo = res_q.lo;
    assign cy_out = res_q.cy;
    assign ac_out = res_q.ac;
    assign ov_out = res_q.ov;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       issue,
    input logic [3:0] op,
    input logic       use_imm,
    input logic [7:0] acc,
    input logic [7:0] code_byte,
    input logic [7:0] reg_byte,
    input logic       cy_in,
    input logic       ac_in,
    input logic       ov_in,
    input logic [7:0] res_hi,
    input logic [7:0] res_lo,
    input logic       cy_out,
    input logic       ac_out,
    input logic       ov_out
);
    logic [7:0] b_seen;
    assign b_seen = use_imm ? code_byte : reg_byte;

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable({res_hi, res_lo, cy_out, ac_out, ov_out}));

    a_r7_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op >= 4'd5 && op <= 4'd8) |=>
            (res_hi == 8'h00) && (cy_out == $past(cy_in)) &&
            (ac_out == $past(ac_in)) && (ov_out == $past(ov_in)));

    a_r8_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 4'd9) |=> !cy_out && (ov_out == (res_hi != 8'h00)));

    a_r9_div_remainder: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 4'd10 && b_seen != 8'h00) |=>
            !ov_out && !cy_out && (res_hi < $past(b_seen)));

    a_r10_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 4'd10 && b_seen == 8'h00) |=>
            ov_out && !cy_out && (res_lo == 8'hFF) && (res_hi == $past(acc)));

    a_r11_da_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 4'd11 && cy_in) |=> cy_out);
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [3:0] op = '0;
    logic       use_imm = 1'b0;
    logic [7:0] acc = '0, code_byte = '0, reg_byte = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic [7:0] res_hi, res_lo;
    logic       cy_out, ac_out, ov_out;

    int checks = 0;
    int errors = 0;

    int e_hi = 0, e_lo = 0, e_cy = 0, e_ac = 0, e_ov = 0;

    always #(CLK_P/2) clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .use_imm(use_imm),
        .acc(acc), .code_byte(code_byte), .reg_byte(reg_byte),
        .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .res_hi(res_hi), .res_lo(res_lo),
        .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
    );

    function automatic string tag_of(int o, int b);
        if (o <= 1) return "R4";
        if (o == 2) return "R5";
        if (o <= 4) return "R6";
        if (o <= 8) return "R7";
        if (o == 9) return "R8";
        if (o == 10) return (b == 0) ? "R10" : "R9";
        if (o == 11) return "R11";
        return "R12";
    endfunction

    task automatic model(int o, int a, int b, int c, int h, int v);
        int s, sa, sb;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        e_hi = 0; e_lo = a; e_cy = c; e_ac = h; e_ov = v;
        case (o)
            0, 1: begin
                int ci;
                ci = (o == 1) ? c : 0;
                s = a + b + ci;
                e_lo = s % 256; e_cy = (s > 255);
                e_ac = ((a % 16) + (b % 16) + ci) > 15;
                e_ov = ((sa + sb + ci) > 127) || ((sa + sb + ci) < -128);
            end
            2: begin
                s = a - b - c;
                e_lo = (s + 256) % 256; e_cy = (s < 0);
                e_ac = ((a % 16) - (b % 16) - c) < 0;
                e_ov = ((sa - sb - c) > 127) || ((sa - sb - c) < -128);
            end
            3: e_lo = (a + 1) % 256;
            4: e_lo = (a + 255) % 256;
            5: e_lo = a & b;
            6: e_lo = a | b;
            7: e_lo = a ^ b;
            8: e_lo = 255 - a;
            9: begin
                s = a * b;
                e_hi = s / 256; e_lo = s % 256; e_cy = 0; e_ov = (s > 255);
            end
            10: begin
                e_cy = 0;
                if (b == 0) begin e_ov = 1; e_lo = 255; e_hi = a; end
                else begin e_ov = 0; e_lo = a / b; e_hi = a % b; end
            end
            11: begin
                s = a;
                if ((s % 16) > 9 || h == 1) s = s + 6;
                if (s > 255) e_cy = 1;
                s = s % 256;
                if ((s / 16) > 9 || e_cy == 1) s = s + 96;
                if (s > 255) e_cy = 1;
                e_lo = s % 256;
            end
            default: ;
        endcase
    endtask

    task automatic compare(string tag);
        checks++;
        if (res_hi != e_hi[7:0] || res_lo != e_lo[7:0] || cy_out != e_cy[0] ||
            ac_out != e_ac[0] || ov_out != e_ov[0]) begin
            errors++;
            $display("FAIL %s: got hi=%h lo=%h cy=%b ac=%b ov=%b exp hi=%h lo=%h cy=%0d ac=%0d ov=%0d",
                     tag, res_hi, res_lo, cy_out, ac_out, ov_out,
                     e_hi[7:0], e_lo[7:0], e_cy, e_ac, e_ov);
        end
    endtask

    // Drive after a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(bit iss, int o, bit imm, int a, int cb, int rb,
                        bit c, bit h, bit v, string tag);
        int b;
        issue = iss; op = o[3:0]; use_imm = imm; acc = a[7:0];
        code_byte = cb[7:0]; reg_byte = rb[7:0];
        cy_in = c; ac_in = h; ov_in = v;
        b = imm ? cb : rb;
        @(posedge clk);
        if (iss && rst_n) model(o, a, b, c, h, v);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: issue during reset is ignored, outputs stay zero
        step(1, 9, 1, 255, 255, 0, 1, 1, 1, "R1");
        step(1, 1, 0, 200, 0, 100, 1, 1, 1, "R1");
        rst_n = 1'b1;

        // R4: add corners, carry-in sensitivity with the same op
        step(1, 0, 1, 8'h7F, 8'h01, 0, 1, 0, 0, "R4");
        step(1, 0, 1, 8'hFF, 8'h01, 0, 0, 0, 0, "R4");
        step(1, 1, 0, 8'h0F, 0, 8'h00, 1, 0, 0, "R4");
        step(1, 1, 0, 8'h0F, 0, 8'h00, 0, 0, 0, "R4");
        step(1, 0, 1, 8'h80, 8'h80, 0, 0, 0, 0, "R4");
        // R2: idle cycles hold the last result even when inputs move
        step(0, 9, 1, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, "R2");
        step(0, 2, 0, 8'h12, 8'h34, 8'h56, 0, 1, 0, "R2");
        // R5: subtract with borrow corners
        step(1, 2, 1, 8'h00, 8'h01, 0, 0, 0, 0, "R5");
        step(1, 2, 1, 8'h80, 8'h00, 0, 1, 0, 0, "R5");
        step(1, 2, 1, 8'h10, 8'h01, 0, 0, 0, 0, "R5");
        step(1, 2, 1, 8'h10, 8'h01, 0, 1, 0, 0, "R5");
        // R3: operand select
        step(1, 5, 1, 8'hF0, 8'h3C, 8'hC3, 0, 0, 0, "R3");
        step(1, 5, 0, 8'hF0, 8'h3C, 8'hC3, 0, 0, 0, "R3");
        // R6: wrap of increment / decrement
        step(1, 3, 0, 8'hFF, 0, 0, 1, 0, 1, "R6");
        step(1, 4, 0, 8'h00, 0, 0, 0, 1, 0, "R6");
        // R7: logic ops pass flags
        step(1, 6, 0, 8'hA0, 0, 8'h05, 1, 1, 1, "R7");
        step(1, 7, 1, 8'hFF, 8'h0F, 0, 0, 1, 0, "R7");
        step(1, 8, 0, 8'h5A, 0, 0, 1, 0, 1, "R7");
        // R8: multiply
        step(1, 9, 1, 8'hFF, 8'hFF, 0, 1, 0, 0, "R8");
        step(1, 9, 0, 8'h0F, 0, 8'h11, 1, 1, 1, "R8");
        // R9, R10: divide
        step(1, 10, 0, 8'hFB, 0, 8'h12, 1, 0, 1, "R9");
        step(1, 10, 1, 8'h07, 8'hFF, 0, 0, 0, 0, "R9");
        step(1, 10, 1, 8'h9C, 8'h00, 0, 1, 1, 0, "R10");
        step(1, 10, 0, 8'h00, 8'h01, 8'h00, 0, 0, 0, "R10");
        // R11: decimal adjust
        step(1, 11, 0, 8'h9A, 0, 0, 0, 0, 0, "R11");
        step(1, 11, 0, 8'h00, 0, 0, 1, 1, 0, "R11");
        step(1, 11, 0, 8'h3B, 0, 0, 0, 0, 1, "R11");
        step(1, 11, 0, 8'h99, 0, 0, 0, 0, 0, "R11");
        // R12: unused codes
        step(1, 12, 1, 8'h42, 8'h11, 0, 1, 0, 1, "R12");
        step(1, 15, 0, 8'hC8, 0, 8'h77, 0, 1, 0, "R12");

        // Pseudo-random sweep with idle cycles interleaved
        for (int n = 0; n < 4000; n++) begin
            int o, a, cb, rb;
            bit iss, imm;
            iss = ($urandom % 5) != 0;
            o   = $urandom % 16;
            imm = $urandom % 2;
            a   = $urandom % 256;
            cb  = ($urandom % 8 == 0) ? 0 : $urandom % 256;
            rb  = ($urandom % 8 == 0) ? 0 : $urandom % 256;
            step(iss, o, imm, a, cb, rb, $urandom % 2, $urandom % 2, $urandom % 2,
                 iss ? tag_of(o, imm ? cb : rb) : "R2");
        end

        // R1: reset clears held result
        rst_n = 1'b0;
        e_hi = 0; e_lo = 0; e_cy = 0; e_ac = 0; e_ov = 0;
        step(1, 9, 1, 8'hFF, 8'hFF, 0, 1, 1, 1, "R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule